// File: doc/BRIEF.md
# Sense Amplifier Recovery Self-Test Sequencer

This block is a built-in self-test engine for a single-port synchronous RAM. It looks for a defect that ordinary cell tests miss: a read or write path that recovers too slowly after a long run of accesses carrying one value. When such a run is followed at once by a read of a word holding the opposite value, a slow sense path can still return the old value. Fault models aimed at individual cells do not target this defect.

On `start` the sequencer writes a periodic background. Each period is `RUN_LEN` run words carrying the background value, followed by one target word carrying the opposite value. It then sweeps the array twice. The first sweep reads every word, so each target read follows a long run of background reads. The second sweep writes the background into the run words and reads only the targets, so each target read follows a long run of writes. The whole procedure runs first with a 0 background and 1 targets, then with a 1 background and 0 targets. Every read is compared against the value the background predicts. The first mismatch raises `fail` and stores its address. `done` marks the end of the run.

Top module: `srt_recovery_bist`

## Requirements
- R1: A synchronous active-high reset, applied at any time, drives `done`, `fail`, `mem_en`, `mem_we` low and `fail_addr` to zero. The block then stays quiet until `start`.
- R2: `start` is accepted only when the block is idle or finished. The first command appears on the RAM port one cycle after the accepting clock edge, at address 0. A `start` during a run has no effect on the command stream.
- R3: A run issues exactly 6 x 2^AW commands, one per cycle with `mem_en` high and no gaps. It is made of six ascending address sweeps from 0 to 2^AW-1: fill, read sweep, write sweep with polarity 0, then the same three with polarity 1.
- R4: An address is a target when (address mod (RUN_LEN+1)) equals RUN_LEN. The fill sweep writes every word, all bits equal to polarity XOR target (polarity 0 gives 0x00 run words and all-ones targets).
- R5: The read sweep reads every address (`mem_we` low). The run words are expected to hold the polarity value and the targets its complement.
- R6: The write sweep writes the polarity value into every run word and reads each target in the cycle right after the last run write before it.
- R7: Read data is taken one cycle after the read command is on the port. All `DW` bits are compared against the expected value.
- R8: The first read mismatch sets `fail` and loads `fail_addr` with that read's address. Both hold through later mismatches until the next accepted `start`.
- R9: `done` rises two cycles after the last command of the run, with `fail` already final, and stays high with `mem_en` low until the next `start`. An accepted `start` clears `done` and `fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test run (idle or finished only) |
| done | output | 1 | Run complete, result valid |
| fail | output | 1 | A read mismatch was seen |
| fail_addr | output | AW | Address of the first mismatching read |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable (0 = read) |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | DW | RAM write data |
| mem_rdata | input | DW | RAM read data, valid one cycle after a read |

## Verification
The hardest condition to create from the ports is a genuine recovery failure. The target read must return the wrong value only after a run of at least a given length with the same data. One variant counts only write runs and another counts only falls to zero. The bench RAM model therefore tracks how many consecutive accesses carried the same data and whether all of them were writes. It corrupts a chosen target read only when that history meets a configured threshold. With a threshold equal to the run length the fault fires, and with one more it must stay silent. Random stuck bits at random addresses and a random mid-run `start` fill out the stimulus.

// File: rtl/srt_pkg.sv
package srt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_RDRUN,
    ST_WRRUN,
    ST_DRAIN1,
    ST_DRAIN2,
    ST_FINISH
  } srt_state_e;
endpackage

// File: rtl/srt_addr_walk.sv
module srt_addr_walk #(
  parameter int AW      = 8,
  parameter int RUN_LEN = 63
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          is_tgt,
  output logic          last
);
  localparam int            PW       = $clog2(RUN_LEN + 1);
  localparam logic [PW-1:0] TGT_POS  = PW'(RUN_LEN);
  localparam logic [AW-1:0] ADDR_MAX = '1;

  logic [PW-1:0] pos;

  assign is_tgt = (pos == TGT_POS);
  assign last   = (addr == ADDR_MAX);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      addr <= '0;
      pos  <= '0;
    end else if (step) begin
      if (last) begin
        addr <= '0;
        pos  <= '0;
      end else begin
        addr <= addr + 1'b1;
        pos  <= is_tgt ? '0 : pos + 1'b1;
      end
    end
  end

  // R3
  walk_step_chk: assert property (@(posedge clk) disable iff (rst)
    step && !clr && !last |=> addr == $past(addr) + 1'b1);

  // R4
  walk_pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    pos <= TGT_POS);
endmodule

// File: rtl/srt_phase_fsm.sv
module srt_phase_fsm
  import srt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       last,
  output srt_state_e state,
  output logic       pol,
  output logic       step,
  output logic       accept,
  output logic       done
);
  srt_state_e nxt;
  logic       nxt_pol;

  assign step   = (state == ST_FILL) || (state == ST_RDRUN) || (state == ST_WRRUN);
  assign accept = start && ((state == ST_IDLE) || (state == ST_FINISH));

  always_comb begin
    nxt     = state;
    nxt_pol = pol;
    case (state)
      ST_IDLE, ST_FINISH: begin
        if (start) begin
          nxt     = ST_FILL;
          nxt_pol = 1'b0;
        end
      end
      ST_FILL:  if (last) nxt = ST_RDRUN;
      ST_RDRUN: if (last) nxt = ST_WRRUN;
      ST_WRRUN: begin
        if (last) begin
          if (pol) begin
            nxt = ST_DRAIN1;
          end else begin
            nxt     = ST_FILL;
            nxt_pol = 1'b1;
          end
        end
      end
      ST_DRAIN1: nxt = ST_DRAIN2;
      ST_DRAIN2: nxt = ST_FINISH;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      pol   <= 1'b0;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      pol   <= nxt_pol;
      done  <= (nxt == ST_FINISH);
    end
  end

  // R9
  fsm_finish_hold_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_FINISH && !start |=> state == ST_FINISH && done);

  // R3
  fsm_pol_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pol) |-> $past(state) == ST_WRRUN);

  // R2
  fsm_busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    step && !last |=> $stable(state) && $stable(pol));
endmodule

// File: rtl/srt_resp_check.sv
module srt_resp_check #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          iss_chk,
  input  logic          iss_exp,
  input  logic [AW-1:0] iss_addr,
  input  logic [DW-1:0] rdata,
  output logic          fail,
  output logic [AW-1:0] fail_addr
);
  logic          chk_d;
  logic          exp_d;
  logic [AW-1:0] addr_d;
  logic          miss;

  assign miss = chk_d && (rdata != {DW{exp_d}});

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_d     <= 1'b0;
      exp_d     <= 1'b0;
      addr_d    <= '0;
      fail      <= 1'b0;
      fail_addr <= '0;
    end else begin
      chk_d  <= iss_chk;
      exp_d  <= iss_exp;
      addr_d <= iss_addr;
      if (clear) begin
        fail      <= 1'b0;
        fail_addr <= '0;
      end else if (miss && !fail) begin
        fail      <= 1'b1;
        fail_addr <= addr_d;
      end
    end
  end

  // R8
  chk_fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fail && !clear |=> fail);

  // R8
  chk_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fail && !clear |=> $stable(fail_addr));
endmodule

// File: rtl/srt_recovery_bist.sv
module srt_recovery_bist
  import srt_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter int RUN_LEN = 63
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  srt_state_e    state;
  logic          pol, step, accept, last, is_tgt;
  logic [AW-1:0] walk_addr;
  logic          op_we, op_val;
  logic          iss_chk, iss_exp;

  srt_phase_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .last(last),
    .state(state), .pol(pol), .step(step), .accept(accept), .done(done)
  );

  srt_addr_walk #(.AW(AW), .RUN_LEN(RUN_LEN)) u_walk (
    .clk(clk), .rst(rst), .clr(accept), .step(step),
    .addr(walk_addr), .is_tgt(is_tgt), .last(last)
  );

  assign op_val = is_tgt ^ pol;
  assign op_we  = (state == ST_FILL) || ((state == ST_WRRUN) && !is_tgt);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      iss_chk   <= 1'b0;
      iss_exp   <= 1'b0;
    end else begin
      mem_en    <= step;
      mem_we    <= step && op_we;
      mem_addr  <= walk_addr;
      mem_wdata <= {DW{op_val}};
      iss_chk   <= step && !op_we;
      iss_exp   <= op_val;
    end
  end

  srt_resp_check #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .clear(accept),
    .iss_chk(iss_chk), .iss_exp(iss_exp), .iss_addr(mem_addr),
    .rdata(mem_rdata), .fail(fail), .fail_addr(fail_addr)
  );

  // R3
  cmd_contig_chk: assert property (@(posedge clk) disable iff (rst)
    mem_en && (mem_addr != {AW{1'b1}}) |=> mem_en && (mem_addr == $past(mem_addr) + 1'b1));

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_en);
endmodule

// File: tb/tb_srt_recovery_bist.sv
`timescale 1ns/1ps
module tb_srt_recovery_bist;
  localparam int AW = 8, DW = 8, RUN_LEN = 63;
  localparam int D = 1 << AW, P = RUN_LEN + 1, CW = 2 + AW + DW;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic done, fail, mem_en, mem_we;
  logic [AW-1:0] fail_addr, mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  int unsigned nchk = 0, nbad = 0;

  // fault injection controls
  logic stk_en = 0, stk_val = 0; logic [AW-1:0] stk_addr = '0; int stk_bit = 0;
  logic rec_en = 0, rec_wr = 0, rec_to0 = 0; logic [AW-1:0] rec_addr = '0; int rec_t = 0;

  always #2 clk = ~clk;

  srt_recovery_bist #(.AW(AW), .DW(DW), .RUN_LEN(RUN_LEN)) dut (
    .clk(clk), .rst(rst), .start(start), .done(done), .fail(fail), .fail_addr(fail_addr),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // RAM model with a history-dependent recovery fault
  logic [DW-1:0] mem [D];
  logic [DW-1:0] prev_d;
  int            streak;
  logic          all_wr;
  always @(posedge clk) begin
    logic [DW-1:0] cor, opd, outv;
    if (rst) begin
      prev_d <= '0; streak <= 0; all_wr <= 1'b0; mem_rdata <= '0;
    end else if (mem_en) begin
      cor = mem[mem_addr];
      opd = mem_we ? mem_wdata : cor;
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else begin
        outv = cor;
        if (stk_en && mem_addr == stk_addr) outv[stk_bit] = stk_val;
        if (rec_en && mem_addr == rec_addr && cor != prev_d && streak >= rec_t &&
            (!rec_wr || all_wr) && (!rec_to0 || cor == '0)) outv = prev_d;
        mem_rdata <= outv;
      end
      if (opd == prev_d) begin streak <= streak + 1; all_wr <= all_wr & mem_we; end
      else begin streak <= 1; all_wr <= mem_we; end
      prev_d <= opd;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // expected command for cycle k of a run: {en, we, addr, wdata-or-0}
  function automatic logic [CW-1:0] exp_cmd(input int k);
    int p, ph, a; bit tgt, v, we;
    p = k / (3 * D); ph = (k / D) % 3; a = k % D;
    tgt = (a % P) == RUN_LEN;
    v = tgt ^ p[0];
    we = (ph == 0) || (ph == 2 && !tgt);
    return {1'b1, we, AW'(a), we ? {DW{v}} : {DW{1'b0}}};
  endfunction

  task automatic clear_faults();
    stk_en = 0; rec_en = 0; rec_wr = 0; rec_to0 = 0;
  endtask

  task automatic run_seq(input int mid_start, input bit exp_fail, input logic [AW-1:0] exp_addr, input string tag);
    logic [CW-1:0] e, a;
    string ptag;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(mem_en == 1'b0, "R2 no command before latency", mem_en, 0);
    for (int k = 0; k < 6 * D; k++) begin
      @(negedge clk);
      start = (k == mid_start);
      if (k == 0) begin
        chk(done == 1'b0 && fail == 1'b0, "R9 start clears done/fail", {done, fail}, 0);
        chk(mem_en && mem_addr == '0, "R2 first command at addr 0", {mem_en, mem_addr}, {1'b1, {AW{1'b0}}});
      end
      e = exp_cmd(k);
      a = {mem_en, mem_we, mem_addr, mem_we ? mem_wdata : {DW{1'b0}}};
      chk(a[CW-1] == e[CW-1] && a[AW+DW-1:DW] == e[AW+DW-1:DW], "R3 order/address", a, e);
      case ((k / D) % 3)
        0: ptag = "R4 fill";
        1: ptag = "R5 read sweep";
        default: ptag = "R6 write sweep";
      endcase
      chk(a[CW-2] == e[CW-2] && a[DW-1:0] == e[DW-1:0], ptag, a, e);
    end
    start = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R9 done not early", done, 0);
    @(negedge clk);
    chk(done == 1'b1, "R9 done after drain", done, 1);
    chk(fail == exp_fail, {"R7/R8 fail flag ", tag}, fail, exp_fail);
    if (exp_fail) chk(fail_addr == exp_addr, {"R8 fail_addr ", tag}, fail_addr, exp_addr);
    repeat (3) @(negedge clk);
    chk(done == 1'b1 && mem_en == 1'b0, "R9 done holds, port quiet", {done, mem_en}, 2'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL R9 watchdog act=%0d exp=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    logic [AW-1:0] x;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 0 && fail == 0, "R1 reset flags", {done, fail}, 0);
    chk(mem_en == 0 && mem_we == 0, "R1 reset port", {mem_en, mem_we}, 0);
    chk(fail_addr == '0, "R1 reset fail_addr", fail_addr, 0);

    // clean run with a start pulse in the middle (R2: ignored)
    run_seq(1 + int'($urandom % (6 * D - 3)), 1'b0, '0, "clean+midstart");

    // random stuck bits
    for (int i = 0; i < 3; i++) begin
      clear_faults();
      stk_en = 1; stk_addr = AW'($urandom); stk_bit = int'($urandom % DW); stk_val = 1'($urandom);
      run_seq(-1, 1'b1, stk_addr, "stuck bit");
    end

    // recovery after read run of exactly RUN_LEN
    clear_faults();
    x = AW'(int'($urandom % (D / P)) * P + RUN_LEN);
    rec_en = 1; rec_addr = x; rec_t = RUN_LEN;
    run_seq(-1, 1'b1, x, "read-run recovery");

    // threshold one longer than the run: never triggered
    rec_t = RUN_LEN + 1;
    run_seq(-1, 1'b0, '0, "threshold above run");

    // write-run only fault, and write-run fault on falls to zero
    clear_faults();
    x = AW'(int'($urandom % (D / P)) * P + RUN_LEN);
    rec_en = 1; rec_addr = x; rec_t = RUN_LEN; rec_wr = 1;
    run_seq(-1, 1'b1, x, "write-run recovery");
    rec_to0 = 1;
    x = AW'(RUN_LEN);
    rec_addr = x;
    run_seq(-1, 1'b1, x, "write-run fall to 0");

    // clean run after failure: fail cleared and stays clear
    clear_faults();
    run_seq(-1, 1'b0, '0, "clean after fail");

    // reset in the middle of a run
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (100) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(mem_en == 0 && done == 0 && fail == 0, "R1 mid-run reset", {mem_en, done, fail}, 0);
    repeat (5) @(negedge clk);
    chk(mem_en == 0, "R1 idle after reset", mem_en, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule